// File: doc/BRIEF.md
# Colour Bar Test Pattern Generator

This block turns a horizontal pixel position into an eight-bar colour test pattern. Its outputs are ready for a 10-bit video DAC back end. A timing generator supplies the pixel count and a flag marking active lines. For every pixel the block returns three things: a luma code, a chroma amplitude code and a bar index that a later modulator uses as the subcarrier phase selector. The bar edges are fixed pixel positions for each of two 27 MHz line standards: a 525-line standard with 858 pixels per line and a 625-line standard with 864 pixels per line.

A two-bit level control scales the pattern to full, three-quarter, half or quarter amplitude around the blanking level. In the 525-line standard a black-level setup option raises black by 7.5 IRE. An overlay source can replace the bar colours and keep the bar timing. The block does not do subcarrier modulation, filtering or DAC conversion.

Top module: `cbar_gen`

## Requirements
- R1: `bar_idx_o` numbers the bars left to right as 0 white, 1 yellow, 2 cyan, 3 green, 4 magenta, 5 red, 6 blue, 7 black. It is 0 whenever `bar_valid_o` is low.
- R2: With `pal_mode`=0 the bars start at pixel 128. Bar k ends just before 217, 306, 395, 484, 572, 661, 750 and 858 for k=0..7, so pixel 217 already belongs to yellow.
- R3: With `pal_mode`=1 the bars start at pixel 132. Bar k ends just before 223, 314, 405, 496, 582, 670, 757 and 864.
- R4: In the 525-line standard with `setup_en`=1, full-level luma codes by bar are 775, 718, 623, 565, 476, 418, 324, 266.
- R5: Without setup, full-level luma codes by bar are 775, 713, 611, 548, 452, 389, 287, 224.
- R6: In the 625-line standard `setup_en` has no effect, and the R5 table applies.
- R7: Full-level chroma amplitudes (offset from the zero-chroma code 512) by bar are 0, 242, 346, 324, 324, 346, 242, 0 with setup. They are 0, 246, 348, 325, 325, 348, 246, 0 without setup.
- R8: If `line_active` is 0, or the pixel lies before the first bar or at or past the last bar end, the block outputs luma 224 (blanking), chroma amplitude 0, bar index 0 and `bar_valid_o`=0.
- R9: `amp_sel` 00/01/10/11 selects 100/75/50/25 %. With x the luma offset above 224, or the chroma amplitude, the scaled value is x, (x>>1)+(x>>2), x>>1 or x>>2. The luma output is 224 plus the scaled offset.
- R10: With `ovl_sel`=1, in-bar pixels take `ovl_luma` as the luma offset above blanking and `ovl_chroma` as the chroma amplitude. Both are scaled as in R9.
- R11: Outputs are registered. They reflect the inputs sampled one clock earlier. While `rst_n` is low they hold luma 224, amplitude 0, index 0 and not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_cnt | input | 10 | Horizontal pixel position within the line |
| line_active | input | 1 | High on lines that carry picture |
| pal_mode | input | 1 | 0: 858-pixel line, 1: 864-pixel line |
| amp_sel | input | 2 | Pattern level select |
| setup_en | input | 1 | 7.5 IRE black setup (858-pixel standard only) |
| ovl_sel | input | 1 | Use overlay colour instead of bar colour |
| ovl_luma | input | 9 | Overlay luma offset above blanking |
| ovl_chroma | input | 9 | Overlay chroma amplitude |
| luma_o | output | 10 | Luma DAC code |
| chroma_amp_o | output | 10 | Chroma amplitude around 512 |
| bar_idx_o | output | 3 | Bar index / chroma phase selector |
| bar_valid_o | output | 1 | Pixel lies inside a bar on an active line |

## Verification
The chroma bound and the neutral-bar assertions assume that `ovl_sel` is held low whenever the bar colours are being checked. Overlay amplitudes are free, so those properties are enabled only by the overlay select of the previous cycle. The pixel count is assumed to stay below 1024. No assertion assumes that the count rises monotonically, because the stimulus jumps between arbitrary positions, standards and levels on consecutive cycles. The overlay vectors use offsets small enough that blanking plus offset fits in ten bits.

// File: rtl/cbar_pkg.sv
package cbar_pkg;
   localparam int unsigned NBARS      = 8;
   localparam int unsigned BLANK_CODE = 224;
   localparam int unsigned CAMP_MAX   = 348;

   // k = 0: first bar start, k = 1..8: end of bar k-1
   function automatic int unsigned bar_edge(input logic pal, input int unsigned k);
      int unsigned e;
      case (k)
         0: e = pal ? 132 : 128;
         1: e = pal ? 223 : 217;
         2: e = pal ? 314 : 306;
         3: e = pal ? 405 : 395;
         4: e = pal ? 496 : 484;
         5: e = pal ? 582 : 572;
         6: e = pal ? 670 : 661;
         7: e = pal ? 757 : 750;
         default: e = pal ? 864 : 858;
      endcase
      return e;
   endfunction

   function automatic int unsigned bar_luma(input logic [2:0] i, input logic setup);
      int unsigned v;
      case (i)
         3'd0: v = 775;
         3'd1: v = setup ? 718 : 713;
         3'd2: v = setup ? 623 : 611;
         3'd3: v = setup ? 565 : 548;
         3'd4: v = setup ? 476 : 452;
         3'd5: v = setup ? 418 : 389;
         3'd6: v = setup ? 324 : 287;
         default: v = setup ? 266 : 224;
      endcase
      return v;
   endfunction

   function automatic int unsigned bar_camp(input logic [2:0] i, input logic setup);
      int unsigned v;
      case (i)
         3'd1, 3'd6: v = setup ? 242 : 246;
         3'd2, 3'd5: v = setup ? 346 : 348;
         3'd3, 3'd4: v = setup ? 324 : 325;
         default:    v = 0;
      endcase
      return v;
   endfunction
endpackage

// File: rtl/cbar_locator.sv
module cbar_locator
   import cbar_pkg::*;
#(
   parameter int PIX_W = 10
) (
   input  logic [PIX_W-1:0] pix,
   input  logic             active,
   input  logic             pal,
   output logic [2:0]       idx,
   output logic             in_bar
);
   localparam int unsigned MAX_TOTAL = 864;

   generate
      if ((1 << PIX_W) <= MAX_TOTAL) begin : g_bad_width
         $error("cbar_locator: PIX_W too small for line length");
      end
   endgenerate

   logic [NBARS-1:1] past_edge;

   genvar k;
   generate
      for (k = 1; k < NBARS; k++) begin : g_edge
         assign past_edge[k] = ({22'd0, pix} >= 32'(bar_edge(pal, k)));
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int j = 1; j < NBARS; j++) begin
         if (past_edge[j]) idx = 3'(j);
      end
      in_bar = active
             && ({22'd0, pix} >= 32'(bar_edge(pal, 0)))
             && ({22'd0, pix} <  32'(bar_edge(pal, NBARS)));
   end
endmodule

// File: rtl/cbar_scale.sv
module cbar_scale #(
   parameter int W = 10
) (
   input  logic [W-1:0] x,
   input  logic [1:0]   sel,
   output logic [W-1:0] y
);
   generate
      if (W < 3) begin : g_bad_width
         $error("cbar_scale: W must be at least 3");
      end
   endgenerate

   always_comb begin
      case (sel)
         2'b00:   y = x;
         2'b01:   y = (x >> 1) + (x >> 2);
         2'b10:   y = x >> 1;
         default: y = x >> 2;
      endcase
   end
endmodule

// File: rtl/cbar_gen.sv
module cbar_gen
   import cbar_pkg::*;
#(
   parameter int PIX_W = 10,
   parameter int DAC_W = 10,
   localparam int OVL_W = DAC_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] pix_cnt,
   input  logic             line_active,
   input  logic             pal_mode,
   input  logic [1:0]       amp_sel,
   input  logic             setup_en,
   input  logic             ovl_sel,
   input  logic [OVL_W-1:0] ovl_luma,
   input  logic [OVL_W-1:0] ovl_chroma,
   output logic [DAC_W-1:0] luma_o,
   output logic [DAC_W-1:0] chroma_amp_o,
   output logic [2:0]       bar_idx_o,
   output logic             bar_valid_o
);
   localparam logic [DAC_W-1:0] BLANK = DAC_W'(BLANK_CODE);

   generate
      if (DAC_W < 10) begin : g_bad_dac
         $error("cbar_gen: DAC_W must be at least 10");
      end
   endgenerate

   logic [2:0]       idx;
   logic             in_bar;
   logic             setup_eff;
   logic [DAC_W-1:0] l_ofs, c_amp, l_sc, c_sc;

   cbar_locator #(.PIX_W(PIX_W)) u_loc (
      .pix(pix_cnt), .active(line_active), .pal(pal_mode),
      .idx(idx), .in_bar(in_bar)
   );

   assign setup_eff = setup_en & ~pal_mode;

   always_comb begin
      if (ovl_sel) begin
         l_ofs = DAC_W'(ovl_luma);
         c_amp = DAC_W'(ovl_chroma);
      end else begin
         l_ofs = DAC_W'(bar_luma(idx, setup_eff) - BLANK_CODE);
         c_amp = DAC_W'(bar_camp(idx, setup_eff));
      end
   end

   cbar_scale #(.W(DAC_W)) u_scl_l (.x(l_ofs), .sel(amp_sel), .y(l_sc));
   cbar_scale #(.W(DAC_W)) u_scl_c (.x(c_amp), .sel(amp_sel), .y(c_sc));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         luma_o       <= BLANK;
         chroma_amp_o <= '0;
         bar_idx_o    <= '0;
         bar_valid_o  <= 1'b0;
      end else if (in_bar) begin
         luma_o       <= BLANK + l_sc;
         chroma_amp_o <= c_sc;
         bar_idx_o    <= idx;
         bar_valid_o  <= 1'b1;
      end else begin
         luma_o       <= BLANK;
         chroma_amp_o <= '0;
         bar_idx_o    <= '0;
         bar_valid_o  <= 1'b0;
      end
   end

   a_r8_blank_off_line: assert property (@(posedge clk) disable iff (!rst_n)
      !line_active |=> (luma_o == BLANK && chroma_amp_o == '0 && !bar_valid_o));

   a_r9_luma_floor: assert property (@(posedge clk) disable iff (!rst_n)
      luma_o >= BLANK);

   a_r7_amp_cap: assert property (@(posedge clk) disable iff (!rst_n)
      !ovl_sel |=> chroma_amp_o <= DAC_W'(CAMP_MAX));

   a_r7_neutral_bars: assert property (@(posedge clk) disable iff (!rst_n)
      !ovl_sel |=> (!bar_valid_o || (bar_idx_o != 3'd0 && bar_idx_o != 3'd7)
                    || chroma_amp_o == '0));

   a_r1_idx_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !bar_valid_o |-> bar_idx_o == 3'd0);
endmodule

// File: tb/tb_cbar_gen.sv
module tb_cbar_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] pix_cnt = '0;
   logic       line_active = 1'b0;
   logic       pal_mode = 1'b0;
   logic [1:0] amp_sel = '0;
   logic       setup_en = 1'b0;
   logic       ovl_sel = 1'b0;
   logic [8:0] ovl_luma = 9'd300;
   logic [8:0] ovl_chroma = 9'd100;
   logic [9:0] luma_o, chroma_amp_o;
   logic [2:0] bar_idx_o;
   logic       bar_valid_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   cbar_gen dut (
      .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .line_active(line_active),
      .pal_mode(pal_mode), .amp_sel(amp_sel), .setup_en(setup_en),
      .ovl_sel(ovl_sel), .ovl_luma(ovl_luma), .ovl_chroma(ovl_chroma),
      .luma_o(luma_o), .chroma_amp_o(chroma_amp_o),
      .bar_idx_o(bar_idx_o), .bar_valid_o(bar_valid_o)
   );

   // {tag4, pix10, act, pal, amp2, setup, ovl, luma10, camp10, idx3, valid}
   localparam int NV = 21;
   localparam logic [43:0] VEC [NV] = '{
      {4'd2,  10'd130, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 10'd775, 10'd0,   3'd0, 1'b1}, // R2 R4 white
      {4'd2,  10'd216, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 10'd775, 10'd0,   3'd0, 1'b1}, // R2 last white
      {4'd2,  10'd217, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 10'd718, 10'd242, 3'd1, 1'b1}, // R2 R7 yellow edge
      {4'd4,  10'd350, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 10'd623, 10'd346, 3'd2, 1'b1}, // R4 cyan
      {4'd4,  10'd400, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 10'd565, 10'd324, 3'd3, 1'b1}, // R4 green
      {4'd4,  10'd500, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 10'd476, 10'd324, 3'd4, 1'b1}, // R4 magenta
      {4'd1,  10'd600, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 10'd418, 10'd346, 3'd5, 1'b1}, // R1 red
      {4'd1,  10'd700, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 10'd324, 10'd242, 3'd6, 1'b1}, // R1 blue
      {4'd7,  10'd857, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 10'd266, 10'd0,   3'd7, 1'b1}, // R7 black
      {4'd8,  10'd858, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 10'd224, 10'd0,   3'd0, 1'b0}, // R8 past end
      {4'd8,  10'd127, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 10'd224, 10'd0,   3'd0, 1'b0}, // R8 before start
      {4'd8,  10'd300, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 10'd224, 10'd0,   3'd0, 1'b0}, // R8 inactive
      {4'd5,  10'd400, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 10'd548, 10'd325, 3'd3, 1'b1}, // R5 green
      {4'd6,  10'd400, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 10'd611, 10'd348, 3'd2, 1'b1}, // R6 R3 cyan
      {4'd3,  10'd860, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 10'd224, 10'd0,   3'd7, 1'b1}, // R3 black
      {4'd3,  10'd864, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 10'd224, 10'd0,   3'd0, 1'b0}, // R3 end
      {4'd9,  10'd130, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 10'd636, 10'd0,   3'd0, 1'b1}, // R9 75 white
      {4'd9,  10'd217, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 10'd471, 10'd121, 3'd1, 1'b1}, // R9 50 yellow
      {4'd9,  10'd350, 1'b1, 1'b0, 2'd3, 1'b1, 1'b0, 10'd323, 10'd86,  3'd2, 1'b1}, // R9 25 cyan
      {4'd10, 10'd400, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 10'd524, 10'd100, 3'd3, 1'b1}, // R10 full
      {4'd10, 10'd400, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 10'd374, 10'd50,  3'd3, 1'b1}  // R10 half
   };

   task automatic check_out(input int tag, input logic [9:0] el, input logic [9:0] ec,
                            input logic [2:0] ei, input logic ev);
      checks++;
      if (luma_o !== el || chroma_amp_o !== ec || bar_idx_o !== ei || bar_valid_o !== ev) begin
         errors++;
         $display("FAIL R%0d: got luma %0d amp %0d idx %0d valid %0b, expected %0d %0d %0d %0b",
                  tag, luma_o, chroma_amp_o, bar_idx_o, bar_valid_o, el, ec, ei, ev);
      end
   endtask

   initial begin : watchdog
      while (cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      checks++;
      $display("FAIL R11: watchdog expired, got hang, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      line_active = 1'b1;
      pix_cnt = 10'd400;
      repeat (3) @(negedge clk);
      check_out(11, 10'd224, 10'd0, 3'd0, 1'b0); // R11 reset state despite active input
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         pix_cnt     = VEC[v][39:30];
         line_active = VEC[v][29];
         pal_mode    = VEC[v][28];
         amp_sel     = VEC[v][27:26];
         setup_en    = VEC[v][25];
         ovl_sel     = VEC[v][24];
         @(negedge clk);
         check_out(int'(VEC[v][43:40]), VEC[v][23:14], VEC[v][13:4], VEC[v][3:1], VEC[v][0]);
      end

      // R11: one-cycle latency: change input, output still old before the edge
      @(negedge clk);
      ovl_sel = 1'b0; amp_sel = 2'd0; setup_en = 1'b1; pal_mode = 1'b0;
      line_active = 1'b1; pix_cnt = 10'd600;
      @(negedge clk);
      check_out(11, 10'd418, 10'd346, 3'd5, 1'b1);
      pix_cnt = 10'd700;
      #1;
      check_out(11, 10'd418, 10'd346, 3'd5, 1'b1); // R11 not yet updated
      @(negedge clk);
      check_out(11, 10'd324, 10'd242, 3'd6, 1'b1);

      // R9: 75 % red, chroma scaling with shift-add
      amp_sel = 2'd1; pix_cnt = 10'd600;
      @(negedge clk);
      check_out(9, 10'd369, 10'd259, 3'd5, 1'b1);

      // R6: setup ignored in 625-line standard at black
      amp_sel = 2'd0; pal_mode = 1'b1; setup_en = 1'b1; pix_cnt = 10'd800;
      @(negedge clk);
      check_out(6, 10'd224, 10'd0, 3'd7, 1'b1);

      // R11: reset mid-line returns to idle outputs
      rst_n = 1'b0; pal_mode = 1'b0; pix_cnt = 10'd400;
      @(negedge clk);
      check_out(11, 10'd224, 10'd0, 3'd0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_out(4, 10'd565, 10'd324, 3'd3, 1'b1); // R4 after reset release

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule